// File: doc/BRIEF.md
# Broadcast Serial Register Write Master

This block is a bus-mapped serial master that sends register words to a group of radio and synthesizer chips over a shared clock and data line. Software first stores a 32-bit payload in two 16-bit halves and picks a serial clock rate in a configuration register. A single write to the control register then supplies a chip-enable bitmask, a frame-length code and flags, and launches the frame. Each enable bit that is set in the mask goes high together, so one frame can reach several chips at once. The payload's low bits go out most significant first, one bit per serial clock period. The busy flag drops when the frame is complete.

With the read flag set, the master samples the return line on every rising serial clock edge. The sampled bits are placed in a read-data register that software collects once busy has cleared. A control write is refused while a frame is running, so software polls busy before it issues the next access.

Top module: `serial_reg_master`

## Requirements
- R1: Register offset 1 holds payload bits 15:0 and offset 2 holds bits 31:16. Each reads back in bits 15:0 of the bus, and the frame sends bits of the concatenation {offset2, offset1}.
- R2: A write to offset 3 with bit 15 set starts a frame when the block is idle. Busy rises on the next clock. Reading offset 3 returns the last accepted control word, with bit 15 replaced by the live busy flag.
- R3: The frame length N comes from control bits 5:0. A value of 0, or any value above 32, means 32. Busy stays high for exactly H*(2N+1) clocks, where H is the half-period in clocks.
- R4: Bits go out on the data line most significant first, starting at payload bit N-1, with one bit per serial clock period. The data line changes only while the serial clock is low.
- R5: Chip enables equal control bits 16+NCS-1:16 for the whole frame, so several can be high at once. All enables are low while idle.
- R6: The enables rise H clocks before the first rising serial clock edge and fall H clocks after the last falling edge.
- R7: Offset 0 bits 3:0 select the rate. Code 0 gives H = DEF_HALF and code k>0 gives H = 2^(k-1). The rate is taken at launch, and a change during a frame does not affect that frame.
- R8: With control bit 8 set, the return line is sampled at each rising serial clock edge. After the frame, offset 4 bits 15:0 hold the last 16 samples, with the earliest of them most significant and zeros above N. A frame without bit 8 leaves offset 4 unchanged.
- R9: A control write while busy is ignored: the running frame's enables and length are unchanged.
- R10: A control write with bit 15 clear starts nothing. Busy and the enables stay low.
- R11: After reset, busy, the enables, the serial clock and the data line are low, and all registers read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| busy | output | 1 | Frame in progress |
| sclk | output | 1 | Serial clock, idle low |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data return |
| chip_en | output | NCS | Active-high chip enables |

## Verification
The bench builds the block with NCS = 4 and DEF_HALF = 3. This keeps rate code 0 distinct from every power-of-two rate and keeps frames short enough to run many random ones. Rate codes 0 to 3 give half-periods of 3, 1, 2 and 4 clocks. Length codes up to 40 cover the clamp to 32, single-bit frames and full 32-bit read frames. A 4-bit mask reaches single-chip, mixed and all-chip broadcast patterns as well as an empty mask.

// File: rtl/srm_pkg.sv
package srm_pkg;

  localparam int unsigned WORD_W   = 32;
  localparam int unsigned HALF_W   = 16;
  localparam int unsigned ADDR_W   = 3;
  localparam int unsigned LEN_W    = 6;
  localparam int unsigned BITS_W   = 7;
  localparam int unsigned RATE_W   = 4;

  localparam int unsigned CTL_RD_BIT  = 8;
  localparam int unsigned CTL_GO_BIT  = 15;
  localparam int unsigned CTL_SEL_LSB = 16;

  typedef enum logic [ADDR_W-1:0] {
    REG_CFG  = 3'd0,
    REG_TXLO = 3'd1,
    REG_TXHI = 3'd2,
    REG_CTRL = 3'd3,
    REG_RXLO = 3'd4
  } reg_addr_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LEAD,
    ST_HIGH,
    ST_LOW,
    ST_TRAIL
  } shift_state_e;

  // Number of bits in a frame from its length code; 0 and codes above 32 mean 32.
  function automatic logic [BITS_W-1:0] frame_bits(input logic [LEN_W-1:0] code);
    logic [BITS_W-1:0] wide;
    wide = {1'b0, code};
    if (code == '0 || wide > BITS_W'(WORD_W))
      return BITS_W'(WORD_W);
    return wide;
  endfunction

  // Serial half-period in system clocks from the rate code.
  function automatic logic [HALF_W-1:0] half_cycles(input logic [RATE_W-1:0] code,
                                                    input logic [HALF_W-1:0] def_half);
    if (code == '0)
      return def_half;
    return HALF_W'(1) << (code - RATE_W'(1));
  endfunction

endpackage

// File: rtl/srm_regs.sv
module srm_regs
  import srm_pkg::*;
#(
  parameter int unsigned NCS = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_wr,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [WORD_W-1:0]    bus_wdata,
  output logic [WORD_W-1:0]    bus_rdata,
  input  logic                 busy,
  input  logic [HALF_W-1:0]    rx_low,
  output logic [RATE_W-1:0]    rate_code,
  output logic [WORD_W-1:0]    tx_word,
  output logic                 launch,
  output logic [NCS-1:0]       sel_mask,
  output logic [LEN_W-1:0]     len_code,
  output logic                 rd_mode
);

  logic [RATE_W-1:0] cfg_q;
  logic [HALF_W-1:0] txlo_q;
  logic [HALF_W-1:0] txhi_q;
  logic [WORD_W-1:0] ctrl_q;

  logic wr_cfg, wr_lo, wr_hi, wr_ctrl;

  assign wr_cfg  = bus_wr && (bus_addr == REG_CFG);
  assign wr_lo   = bus_wr && (bus_addr == REG_TXLO);
  assign wr_hi   = bus_wr && (bus_addr == REG_TXHI);
  assign wr_ctrl = bus_wr && (bus_addr == REG_CTRL);

  // A launch needs the go flag and an idle engine; anything else is dropped.
  assign launch   = wr_ctrl && bus_wdata[CTL_GO_BIT] && !busy;
  assign sel_mask = bus_wdata[CTL_SEL_LSB +: NCS];
  assign len_code = bus_wdata[LEN_W-1:0];
  assign rd_mode  = bus_wdata[CTL_RD_BIT];

  assign rate_code = cfg_q;
  assign tx_word   = {txhi_q, txlo_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= '0;
      txlo_q <= '0;
      txhi_q <= '0;
      ctrl_q <= '0;
    end else begin
      if (wr_cfg) cfg_q  <= bus_wdata[RATE_W-1:0];
      if (wr_lo)  txlo_q <= bus_wdata[HALF_W-1:0];
      if (wr_hi)  txhi_q <= bus_wdata[HALF_W-1:0];
      if (launch) ctrl_q <= bus_wdata;
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      REG_CFG:  bus_rdata = {{(WORD_W-RATE_W){1'b0}}, cfg_q};
      REG_TXLO: bus_rdata = {{(WORD_W-HALF_W){1'b0}}, txlo_q};
      REG_TXHI: bus_rdata = {{(WORD_W-HALF_W){1'b0}}, txhi_q};
      REG_CTRL: begin
        bus_rdata = ctrl_q;
        bus_rdata[CTL_GO_BIT] = busy;
      end
      REG_RXLO: bus_rdata = {{(WORD_W-HALF_W){1'b0}}, rx_low};
      default:  bus_rdata = '0;
    endcase
  end

endmodule

// File: rtl/srm_clkdiv.sv
module srm_clkdiv
  import srm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              restart,
  input  logic [HALF_W-1:0] half_in,
  output logic              tick
);

  logic [HALF_W-1:0] half_q;
  logic [HALF_W-1:0] cnt_q;

  // tick marks the last system clock of each serial half-period
  assign tick = (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      half_q <= HALF_W'(1);
      cnt_q  <= '0;
    end else if (restart) begin
      half_q <= half_in;
      cnt_q  <= half_in - HALF_W'(1);
    end else if (tick) begin
      cnt_q  <= half_q - HALF_W'(1);
    end else begin
      cnt_q  <= cnt_q - HALF_W'(1);
    end
  end

endmodule

// File: rtl/srm_shifter.sv
module srm_shifter
  import srm_pkg::*;
#(
  parameter int unsigned NCS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              launch,
  input  logic [WORD_W-1:0] tx_word,
  input  logic [LEN_W-1:0]  len_code,
  input  logic              rd_mode,
  input  logic [NCS-1:0]    sel_mask,
  input  logic              tick,
  input  logic              miso,
  output logic              sclk,
  output logic              mosi,
  output logic [NCS-1:0]    chip_en,
  output logic              busy,
  output logic [WORD_W-1:0] rx_word,
  output logic              sample_evt,
  output logic              done_evt
);

  shift_state_e      state_q;
  logic [WORD_W-1:0] sh_q;
  logic [BITS_W-1:0] left_q;
  logic [NCS-1:0]    mask_q;
  logic              rd_q;
  logic [BITS_W-1:0] nb;
  logic              active;

  assign nb         = frame_bits(len_code);
  assign active     = (state_q != ST_IDLE);
  assign busy       = active;
  assign sclk       = (state_q == ST_HIGH);
  assign mosi       = active & sh_q[WORD_W-1];
  assign sample_evt = tick && (state_q == ST_LEAD || state_q == ST_LOW);
  assign done_evt   = tick && (state_q == ST_TRAIL);

  for (genvar g = 0; g < NCS; g++) begin : g_en
    assign chip_en[g] = active & mask_q[g];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      sh_q    <= '0;
      left_q  <= '0;
      mask_q  <= '0;
      rd_q    <= 1'b0;
      rx_word <= '0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (launch) begin
            state_q <= ST_LEAD;
            sh_q    <= tx_word << (BITS_W'(WORD_W) - nb);
            left_q  <= nb;
            mask_q  <= sel_mask;
            rd_q    <= rd_mode;
            if (rd_mode) rx_word <= '0;
          end
        end
        ST_LEAD, ST_LOW: begin
          if (tick) begin
            state_q <= ST_HIGH;
            left_q  <= left_q - BITS_W'(1);
            if (rd_q) rx_word <= {rx_word[WORD_W-2:0], miso};
          end
        end
        ST_HIGH: begin
          if (tick) begin
            if (left_q == '0) begin
              state_q <= ST_TRAIL;
            end else begin
              state_q <= ST_LOW;
              sh_q    <= sh_q << 1;
            end
          end
        end
        ST_TRAIL: begin
          if (tick) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/serial_reg_master.sv
module serial_reg_master
  import srm_pkg::*;
#(
  parameter int unsigned NCS      = 4,
  parameter int unsigned DEF_HALF = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [2:0]        bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              busy,
  output logic              sclk,
  output logic              mosi,
  input  logic              miso,
  output logic [NCS-1:0]    chip_en
);

  localparam logic [HALF_W-1:0] DEF_HALF_V = HALF_W'(DEF_HALF);

  logic [RATE_W-1:0] rate_code;
  logic [WORD_W-1:0] tx_word;
  logic              launch_evt;
  logic [NCS-1:0]    sel_mask;
  logic [LEN_W-1:0]  len_code;
  logic              rd_mode;
  logic              tick;
  logic [WORD_W-1:0] rx_word;
  logic              sample_evt;
  logic              done_evt;
  logic [HALF_W-1:0] half_sel;

  assign half_sel = half_cycles(rate_code, DEF_HALF_V);

  srm_regs #(.NCS(NCS)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .busy(busy), .rx_low(rx_word[HALF_W-1:0]),
    .rate_code(rate_code), .tx_word(tx_word), .launch(launch_evt),
    .sel_mask(sel_mask), .len_code(len_code), .rd_mode(rd_mode)
  );

  srm_clkdiv u_div (
    .clk(clk), .rst_n(rst_n), .restart(launch_evt),
    .half_in(half_sel), .tick(tick)
  );

  srm_shifter #(.NCS(NCS)) u_shift (
    .clk(clk), .rst_n(rst_n), .launch(launch_evt), .tx_word(tx_word),
    .len_code(len_code), .rd_mode(rd_mode), .sel_mask(sel_mask),
    .tick(tick), .miso(miso), .sclk(sclk), .mosi(mosi),
    .chip_en(chip_en), .busy(busy), .rx_word(rx_word),
    .sample_evt(sample_evt), .done_evt(done_evt)
  );

endmodule

// File: rtl/srm_checker.sv
module srm_checker #(
  parameter int unsigned NCS = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic           busy,
  input logic           sclk,
  input logic           mosi,
  input logic [NCS-1:0] chip_en,
  input logic           launch_evt,
  input logic           sample_evt,
  input logic           done_evt
);

  p_launch_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    launch_evt |=> busy);

  p_done_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done_evt |=> !busy);

  p_mosi_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk && $past(sclk)) |-> $stable(mosi));

  p_en_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(chip_en));

  p_lead_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !sclk);

  p_sample_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
    sample_evt |=> sclk);

  p_no_relaunch_r9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !launch_evt);

  p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (chip_en == '0 && !sclk));

endmodule

bind serial_reg_master srm_checker #(.NCS(NCS)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .sclk(sclk), .mosi(mosi),
  .chip_en(chip_en), .launch_evt(launch_evt), .sample_evt(sample_evt),
  .done_evt(done_evt)
);

// File: tb/sim_serial_reg_master.sv
module sim_serial_reg_master;

  localparam int CLK_P    = 10;
  localparam int NCS      = 4;
  localparam int DEF_HALF = 3;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           bus_wr = 1'b0;
  logic [2:0]     bus_addr = '0;
  logic [31:0]    bus_wdata = '0;
  logic [31:0]    bus_rdata;
  logic           busy, sclk, mosi;
  logic           miso = 1'b0;
  logic [NCS-1:0] chip_en;

  int checks = 0;
  int errors = 0;
  logic [15:0] rx_hold = '0;

  always #(CLK_P/2) clk = ~clk;

  serial_reg_master #(.NCS(NCS), .DEF_HALF(DEF_HALF)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .busy(busy),
    .sclk(sclk), .mosi(mosi), .miso(miso), .chip_en(chip_en)
  );

  function automatic int exp_len(input int code);
    int c = code & 63;
    return (c == 0 || c > 32) ? 32 : c;
  endfunction

  function automatic int exp_half(input int rate);
    return (rate == 0) ? DEF_HALF : (1 << (rate - 1));
  endfunction

  task automatic check(input bit ok, input string req, input longint act, input longint expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic bus_write(input logic [2:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [2:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  // inj: 0 none, 1 control write mid-frame, 2 rate write mid-frame
  task automatic run_frame(input logic [NCS-1:0] mask, input int code, input bit rd,
                           input logic [31:0] pay, input int rate, input logic [31:0] rpat,
                           input int inj, input logic [31:0] inj_data);
    int n, h, cyc, first_rise, last_fall, nbits, idx, en_bad;
    logic [31:0] got, rx_exp, rd_v, pay_exp;
    bit prev;
    n = exp_len(code); h = exp_half(rate);
    bus_write(3'd0, 32'(rate));
    bus_write(3'd1, {16'hABCD, pay[15:0]});
    bus_write(3'd2, {16'h1234, pay[31:16]});
    bus_read(3'd1, rd_v);
    check(rd_v == {16'h0, pay[15:0]}, "R1 low half", rd_v, {16'h0, pay[15:0]});
    bus_read(3'd2, rd_v);
    check(rd_v == {16'h0, pay[31:16]}, "R1 high half", rd_v, {16'h0, pay[31:16]});
    idx = 0; miso = rpat[0];
    bus_write(3'd3, (32'(mask) << 16) | 32'h8000 | (rd ? 32'h100 : 32'h0) | 32'(code & 255));
    check(busy == 1'b1, "R2 busy after launch", busy, 1);
    cyc = 0; first_rise = -1; last_fall = -1; nbits = 0; got = '0; rx_exp = '0;
    en_bad = 0; prev = 1'b0;
    while (busy && cyc < 100000) begin
      cyc++;
      if (chip_en !== mask) en_bad++;
      if (sclk && !prev) begin
        if (first_rise < 0) first_rise = cyc;
        got = (got << 1) | 32'(mosi);
        rx_exp = (rx_exp << 1) | 32'(miso);
        nbits++;
      end
      if (!sclk && prev) begin
        last_fall = cyc;
        idx++;
        miso = rpat[idx % 32];
      end
      prev = sclk;
      if (cyc == 2) begin
        bus_read(3'd3, rd_v);
        check(rd_v[15] == 1'b1 && rd_v[16 +: NCS] == mask, "R2 control readback busy",
              rd_v, {mask, 16'h8000});
      end
      if (cyc == 3 && inj != 0) begin
        bus_wr = 1'b1;
        bus_addr = (inj == 1) ? 3'd3 : 3'd0;
        bus_wdata = inj_data;
      end
      if (cyc == 4) bus_wr = 1'b0;
      @(negedge clk);
    end
    check(cyc < 100000, "R3 frame ends", cyc, 0);
    check(cyc == h * (2 * n + 1), "R3 busy length", cyc, h * (2 * n + 1));
    check(first_rise == h + 1, "R6 lead time", first_rise, h + 1);
    check(cyc - last_fall + 1 == h, "R6 trail time", cyc - last_fall + 1, h);
    pay_exp = (n == 32) ? pay : (pay & ((32'd1 << n) - 1));
    check(nbits == n && got == pay_exp, "R4 bit order", got, pay_exp);
    check(en_bad == 0, (inj == 1) ? "R9 enables kept" : "R5 enables", en_bad, 0);
    check(chip_en == '0 && !sclk, "R5 enables drop", chip_en, 0);
    if (rd) rx_hold = rx_exp[15:0];
    bus_read(3'd4, rd_v);
    check(rd_v == {16'h0, rx_hold}, rd ? "R8 read capture" : "R8 read kept", rd_v, rx_hold);
  endtask

  initial begin
    logic [31:0] v;
    void'($urandom(32'd7));
    #(CLK_P * 3);
    @(negedge clk);
    // R11 reset state
    check(!busy && chip_en == '0 && !sclk && !mosi, "R11 outputs", {busy, chip_en, sclk, mosi}, 0);
    for (int a = 0; a < 5; a++) begin
      bus_read(3'(a), v);
      check(v == 0, "R11 register", v, 0);
    end
    rst_n = 1'b1;
    @(negedge clk);

    // directed frames
    run_frame(4'b1000, 8'h15, 1'b0, 32'h0003_00C0, 1, 32'h0, 0, 0);        // R3 21-bit
    run_frame(4'b0111, 8'h0D, 1'b0, 32'h0000_1908, 3, 32'h0, 0, 0);        // R5 broadcast
    run_frame(4'b0001, 8'hE5, 1'b1, 32'h0000_0021, 2, 32'hC35A_96F1, 0, 0); // R8 clamp 32
    run_frame(4'b0010, 8'h00, 1'b0, 32'hDEAD_BEEF, 0, 32'h0, 0, 0);        // R7 default rate
    run_frame(4'b0100, 8'h01, 1'b1, 32'h0000_0001, 1, 32'hFFFF_FFFF, 0, 0); // single bit
    run_frame(4'b0011, 8'h10, 1'b0, 32'h0001_A5A5, 2, 32'h0, 1,
              32'h000C_801F);                                              // R9 ignored
    run_frame(4'b1111, 8'h08, 1'b0, 32'h0000_00F0, 3, 32'h0, 2, 32'h1);    // R7 latched
    run_frame(4'b0000, 8'h04, 1'b0, 32'h0000_000A, 1, 32'h0, 0, 0);        // empty mask

    // R10 control write without launch flag
    bus_write(3'd3, 32'h000F_0008);
    repeat (5) @(negedge clk);
    check(!busy && chip_en == '0, "R10 no launch", {busy, chip_en}, 0);

    // random frames
    for (int i = 0; i < 30; i++) begin
      run_frame(4'($urandom), int'($urandom_range(0, 40)), 1'($urandom),
                $urandom, int'($urandom_range(0, 3)), $urandom, 0, 0);
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_P * 200000);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule